// File: doc/BRIEF.md
# Universal Shift Register with Selectable Fill

This block is a small register whose bits all change together, once per clock period, on the falling clock edge. A two-bit operation code picks what happens at each edge. The register can be cleared, shifted toward its least significant end, shifted toward its most significant end, or loaded in parallel from an input word. The rising edge never changes the contents. A value fed back from the outputs through outside logic can therefore pass through the register at most once per clock period.

During a shift, a second two-bit code picks the bit that enters the vacated end. That bit can be a serial input, a fixed 0, a fixed 1, or the bit that has just left the other end, which makes the shift a rotation. An update-enable input that is held low freezes the contents whatever the operation code says. A synchronous reset, sampled on the same falling edge, clears the register and takes priority over every other input. The width defaults to five bits and is set by a parameter. A second parameter can move the active edge to the rising edge.

Top module: `usr_shift_reg`

## Requirements
- R1: When `rst_i` is high at a falling clock edge, `q_o` becomes all zeros after that edge, whatever the levels of `upd_en_i`, `op_i` and the other inputs.
- R2: `q_o` changes only at falling clock edges. It holds its value across every rising edge.
- R3: When `rst_i` is low and `upd_en_i` is low at a falling edge, `q_o` keeps its value for every code on `op_i`.
- R4: Operation code `op_i` = 2'b00 (clear) with updates enabled loads all zeros.
- R5: Operation code 2'b01 (toward LSB) moves each bit i of `q_o` to bit i-1, and bit WIDTH-1 receives the selected fill bit.
- R6: Operation code 2'b10 (toward MSB) moves each bit i of `q_o` to bit i+1, and bit 0 receives the selected fill bit.
- R7: Operation code 2'b11 (load) copies `load_i` into `q_o` at the edge.
- R8: The fill code `fill_i` selects the incoming bit as follows: 2'b00 takes `ser_i`, 2'b01 takes 0, 2'b10 takes 1, and 2'b11 takes the bit shifted out at the opposite end (the old bit 0 on a shift toward LSB, the old bit WIDTH-1 on a shift toward MSB).
- R9: Starting from 5'b01001, five shifts toward LSB with fill code 2'b01 keep bit 4 at 0 after every edge and leave the register at 5'b00000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; the falling edge is the active edge |
| rst_i | input | 1 | Synchronous reset, active high, with highest priority |
| upd_en_i | input | 1 | Update enable; when low, the register holds its contents |
| op_i | input | 2 | Operation: 00 clear, 01 shift toward LSB, 10 shift toward MSB, 11 load |
| fill_i | input | 2 | Fill source: 00 serial, 01 zero, 10 one, 11 rotate |
| ser_i | input | 1 | Serial data bit used when the fill code is 00 |
| load_i | input | WIDTH | Parallel data word used by the load operation |
| q_o | output | WIDTH | Register contents |

## Verification
The register is its own output, so any wrong internal bit is visible on `q_o` right after the falling edge that stores it. A wrong bit stays visible until a clear, load or reset overwrites it. A shift moves it one place per edge, and a rotation keeps it in the register indefinitely. A wrong fill choice is limited to the single end bit it enters, so the bench varies the fill code in both shift directions. A change on the wrong edge shows up as a difference between the sample taken after the falling edge and the sample taken after the following rising edge.

// File: rtl/usr_pkg.sv
package usr_pkg;

   typedef enum logic [1:0] {
      OP_CLEAR = 2'b00,
      OP_SHR   = 2'b01,
      OP_SHL   = 2'b10,
      OP_LOAD  = 2'b11
   } usr_op_e;

   typedef enum logic [1:0] {
      FILL_SER  = 2'b00,
      FILL_ZERO = 2'b01,
      FILL_ONE  = 2'b10,
      FILL_WRAP = 2'b11
   } usr_fill_e;

endpackage

// File: rtl/usr_fill_mux.sv
module usr_fill_mux
   import usr_pkg::*;
(
   input  logic [1:0] sel_i,
   input  logic       ser_i,
   input  logic       wrap_i,
   output logic       fill_o
);

   usr_fill_e sel;

   assign sel = usr_fill_e'(sel_i);

   always_comb begin
      unique case (sel)
         FILL_SER:  fill_o = ser_i;
         FILL_ZERO: fill_o = 1'b0;
         FILL_ONE:  fill_o = 1'b1;
         FILL_WRAP: fill_o = wrap_i;
         default:   fill_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/usr_next_state.sv
module usr_next_state
   import usr_pkg::*;
#(
   parameter int WIDTH = 5
) (
   input  logic [1:0]       op_i,
   input  logic [WIDTH-1:0] cur_i,
   input  logic [WIDTH-1:0] load_i,
   input  logic             fill_lo_i,
   input  logic             fill_hi_i,
   output logic [WIDTH-1:0] nxt_o
);

   localparam int MSB = WIDTH - 1;

   usr_op_e op;

   assign op = usr_op_e'(op_i);

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic from_hi;
      logic from_lo;

      if (i == MSB) begin : g_top
         assign from_hi = fill_hi_i;
      end else begin : g_mid_hi
         assign from_hi = cur_i[i+1];
      end

      if (i == 0) begin : g_bot
         assign from_lo = fill_lo_i;
      end else begin : g_mid_lo
         assign from_lo = cur_i[i-1];
      end

      always_comb begin
         unique case (op)
            OP_CLEAR: nxt_o[i] = 1'b0;
            OP_SHR:   nxt_o[i] = from_hi;
            OP_SHL:   nxt_o[i] = from_lo;
            OP_LOAD:  nxt_o[i] = load_i[i];
            default:  nxt_o[i] = 1'b0;
         endcase
      end
   end

endmodule

// File: rtl/usr_state_reg.sv
module usr_state_reg #(
   parameter int WIDTH        = 5,
   parameter bit FALLING_EDGE = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             en_i,
   input  logic [WIDTH-1:0] nxt_i,
   output logic [WIDTH-1:0] q_o
);

   if (FALLING_EDGE) begin : g_fall
      always_ff @(negedge clk_i) begin
         if (rst_i) begin
            q_o <= '0;
         end else if (en_i) begin
            q_o <= nxt_i;
         end
      end
   end else begin : g_rise
      always_ff @(posedge clk_i) begin
         if (rst_i) begin
            q_o <= '0;
         end else if (en_i) begin
            q_o <= nxt_i;
         end
      end
   end

endmodule

// File: rtl/usr_shift_reg.sv
module usr_shift_reg #(
   parameter int WIDTH        = 5,
   parameter bit FALLING_EDGE = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             upd_en_i,
   input  logic [1:0]       op_i,
   input  logic [1:0]       fill_i,
   input  logic             ser_i,
   input  logic [WIDTH-1:0] load_i,
   output logic [WIDTH-1:0] q_o
);

   localparam int MSB = WIDTH - 1;

   if (WIDTH < 2) begin : g_width_chk
      $error("usr_shift_reg: WIDTH must be at least 2");
   end

   logic             fill_hi;
   logic             fill_lo;
   logic [WIDTH-1:0] nxt;

   usr_fill_mux i_fill_hi (
      .sel_i  (fill_i),
      .ser_i  (ser_i),
      .wrap_i (q_o[0]),
      .fill_o (fill_hi)
   );

   usr_fill_mux i_fill_lo (
      .sel_i  (fill_i),
      .ser_i  (ser_i),
      .wrap_i (q_o[MSB]),
      .fill_o (fill_lo)
   );

   usr_next_state #(
      .WIDTH (WIDTH)
   ) i_next (
      .op_i      (op_i),
      .cur_i     (q_o),
      .load_i    (load_i),
      .fill_lo_i (fill_lo),
      .fill_hi_i (fill_hi),
      .nxt_o     (nxt)
   );

   usr_state_reg #(
      .WIDTH        (WIDTH),
      .FALLING_EDGE (FALLING_EDGE)
   ) i_state (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .en_i  (upd_en_i),
      .nxt_i (nxt),
      .q_o   (q_o)
   );

endmodule

// File: rtl/usr_shift_reg_chk.sv
module usr_shift_reg_chk #(
   parameter int WIDTH = 5
) (
   input logic             clk_i,
   input logic             rst_i,
   input logic             upd_en_i,
   input logic [1:0]       op_i,
   input logic [1:0]       fill_i,
   input logic             ser_i,
   input logic [WIDTH-1:0] load_i,
   input logic [WIDTH-1:0] q_o
);

   localparam int MSB = WIDTH - 1;

   logic act;
   assign act = !rst_i && upd_en_i;

   AST_RESET_ZERO: assert property (@(negedge clk_i) rst_i |=> q_o == '0); // R1

   AST_HOLD_WHEN_IDLE: assert property (@(negedge clk_i) disable iff (rst_i)
      !upd_en_i |=> $stable(q_o)); // R3

   AST_CLEAR_ZERO: assert property (@(negedge clk_i) disable iff (rst_i)
      (act && op_i == 2'b00) |=> q_o == '0); // R4

   AST_SHR_BODY: assert property (@(negedge clk_i) disable iff (rst_i)
      (act && op_i == 2'b01) |=> q_o[MSB-1:0] == $past(q_o[MSB:1])); // R5

   AST_SHL_BODY: assert property (@(negedge clk_i) disable iff (rst_i)
      (act && op_i == 2'b10) |=> q_o[MSB:1] == $past(q_o[MSB-1:0])); // R6

   AST_LOAD_WORD: assert property (@(negedge clk_i) disable iff (rst_i)
      (act && op_i == 2'b11) |=> q_o == $past(load_i)); // R7

   AST_FILL_SER_HI: assert property (@(negedge clk_i) disable iff (rst_i)
      (act && op_i == 2'b01 && fill_i == 2'b00) |=> q_o[MSB] == $past(ser_i)); // R8

   AST_FILL_WRAP_LO: assert property (@(negedge clk_i) disable iff (rst_i)
      (act && op_i == 2'b10 && fill_i == 2'b11) |=> q_o[0] == $past(q_o[MSB])); // R8

   AST_FILL_CONST_HI: assert property (@(negedge clk_i) disable iff (rst_i)
      (act && op_i == 2'b01 && fill_i[1] != fill_i[0]) |=> q_o[MSB] == $past(fill_i[1])); // R8

endmodule

bind usr_shift_reg usr_shift_reg_chk #(.WIDTH(WIDTH)) i_chk (
   .clk_i    (clk_i),
   .rst_i    (rst_i),
   .upd_en_i (upd_en_i),
   .op_i     (op_i),
   .fill_i   (fill_i),
   .ser_i    (ser_i),
   .load_i   (load_i),
   .q_o      (q_o)
);

// File: tb/test_usr_shift_reg.sv
module test_usr_shift_reg;

   localparam int W = 5;

   logic         clk = 1'b0;
   logic         rst;
   logic         en;
   logic [1:0]   op;
   logic [1:0]   fill;
   logic         ser;
   logic [W-1:0] par;
   logic [W-1:0] q;

   int           n_cmp = 0;
   int           n_bad = 0;
   bit           armed = 1'b0;
   logic [W-1:0] model;
   logic         fb;
   string        tag;
   string        phase = "";

   always #4 clk = ~clk;

   usr_shift_reg i_usr_shift_reg (
      .clk_i    (clk),
      .rst_i    (rst),
      .upd_en_i (en),
      .op_i     (op),
      .fill_i   (fill),
      .ser_i    (ser),
      .load_i   (par),
      .q_o      (q)
   );

   function automatic void chk(string t, logic [W-1:0] act, logic [W-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: q=%b expected %b", t, act, exp);
      end
   endfunction

   function automatic logic pick_fill(logic [1:0] f, logic s, logic w);
      case (f)
         2'b00:   return s;
         2'b01:   return 1'b0;
         2'b10:   return 1'b1;
         default: return w;
      endcase
   endfunction

   // reference model, applied at each falling edge; compared 1 ns later
   always @(negedge clk) begin
      if (rst) begin
         model = '0;
         tag = "R1";
      end else if (!en) begin
         tag = "R3";
      end else begin
         case (op)
            2'b00: begin model = '0; tag = "R4"; end
            2'b01: begin
               fb = pick_fill(fill, ser, model[0]);
               model = {fb, model[W-1:1]};
               tag = "R5 R8";
            end
            2'b10: begin
               fb = pick_fill(fill, ser, model[W-1]);
               model = {model[W-2:0], fb};
               tag = "R6 R8";
            end
            default: begin model = par; tag = "R7"; end
         endcase
      end
      if (phase != "") tag = {phase, " ", tag};
      armed = 1'b1;
      #1 chk(tag, q, model);
   end

   // nothing may change on the rising edge
   always @(posedge clk) begin
      #1 if (armed) chk("R2", q, model);
   end

   task automatic go(logic r, logic e, logic [1:0] o, logic [1:0] f, logic s, logic [W-1:0] p);
      @(posedge clk);
      #2;
      rst = r; en = e; op = o; fill = f; ser = s; par = p;
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL R2 watchdog: run incomplete, expected completion");
      summary();
   end

   initial begin
      rst = 1'b1; en = 1'b1; op = 2'b11; fill = 2'b00; ser = 1'b0; par = '1;
      // R1: reset wins over an enabled load
      go(1, 1, 2'b11, 2'b00, 1, 5'b11111);
      go(1, 0, 2'b10, 2'b10, 1, 5'b10101);
      // R7 load
      go(0, 1, 2'b11, 2'b00, 0, 5'b10110);
      // R5 / R8 shift toward LSB with every fill
      go(0, 1, 2'b01, 2'b00, 1, 5'b00000);
      go(0, 1, 2'b01, 2'b00, 0, 5'b00000);
      go(0, 1, 2'b01, 2'b01, 1, 5'b00000);
      go(0, 1, 2'b01, 2'b10, 0, 5'b00000);
      for (int k = 0; k < 3; k++) go(0, 1, 2'b01, 2'b11, 0, 5'b00000);
      // R6 / R8 shift toward MSB with every fill
      go(0, 1, 2'b11, 2'b00, 0, 5'b10011);
      go(0, 1, 2'b10, 2'b00, 1, 5'b00000);
      go(0, 1, 2'b10, 2'b00, 0, 5'b00000);
      go(0, 1, 2'b10, 2'b10, 0, 5'b00000);
      go(0, 1, 2'b10, 2'b01, 1, 5'b00000);
      for (int k = 0; k < 4; k++) go(0, 1, 2'b10, 2'b11, 1, 5'b00000);
      // R3 hold with every code
      for (int k = 0; k < 4; k++) go(0, 0, 2'(k), 2'b10, 1, 5'b01010);
      // R4 clear
      go(0, 1, 2'b00, 2'b10, 1, 5'b11111);
      // R9 drain scenario
      phase = "R9";
      go(0, 1, 2'b11, 2'b00, 0, 5'b01001);
      for (int k = 0; k < 5; k++) begin
         go(0, 1, 2'b01, 2'b01, 1, 5'b11111);
         @(negedge clk); #2;
         n_cmp++;
         if (q[W-1] !== 1'b0) begin
            n_bad++;
            $display("FAIL R9: msb=%b expected 0", q[W-1]);
         end
      end
      chk("R9 final", q, 5'b00000);
      phase = "";
      // mixed traffic
      for (int k = 0; k < 300; k++)
         go($urandom_range(0, 19) == 0, $urandom_range(0, 4) != 0,
            2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
            1'($urandom_range(0, 1)), 5'($urandom_range(0, 31)));
      @(posedge clk); #2;
      summary();
   end

endmodule